// File: doc/BRIEF.md
# Register Rename Unit with Retirement Map

This block renames architectural registers for an out-of-order core whose register values live only in a physical register file. It holds three pieces of state. The first is a speculative map with one entry per architectural register. The second is a retirement map that records the committed mapping. The third is a free-register vector that marks which physical registers can be allocated.

On the dispatch side an instruction presents two source indices and an optional destination index. In the same cycle the block returns the physical tags of the sources and a freshly granted tag for the destination. On the retire side the reorder buffer presents the architectural destination and physical tag of each committing instruction. The block then updates the retirement map and releases the register that the commit displaced. A flush input restores the speculative map from the retirement map in a single cycle. The same flush regenerates the free vector from what the retirement map references.

Top module: `rnm_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i in both maps, and exactly the tags ARCH_REGS..PHYS_REGS-1 are free. A dispatch of source index i returns tag i.
- R2: `dispSrc1Tag` and `dispSrc2Tag` are combinational reads of the speculative map as it stands before this cycle's destination update. A source that equals the destination of the same instruction therefore returns the previous tag.
- R3: An accepted dispatch (`dispValid && dispReady`) with `dispDstEn` set and a destination that is not the zero register receives the lowest-numbered free tag on `dispDstTag` in that cycle. From the next cycle the speculative entry for that destination reads that tag, and the tag is no longer free.
- R4: `dispReady` is low whenever no physical register is free or `flush` is high. A dispatch presented while `dispReady` is low changes no map entry and consumes no tag.
- R5: A retire (`retValid`) writes `retTag` into the retirement entry of `retDstArch`. The tag previously held in that entry becomes free and can be granted from the next cycle.
- R6: In a cycle with `flush` high, the retirement map is copied into the speculative map. The copy includes a retire presented in the same cycle. The free vector becomes exactly the set of tags that the retirement map does not reference.
- R7: With ZERO_REG set, architectural register 0 always reads tag 0. A dispatch to destination 0 allocates nothing and returns `dispDstTag` = 0. A retire to register 0 is ignored.
- R8: `dispDstTag` is 0 in every cycle in which no tag is granted, including dispatches with `dispDstEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| dispValid | input | 1 | Dispatch request present |
| dispReady | output | 1 | Dispatch can be accepted this cycle |
| dispDstEn | input | 1 | Instruction writes a destination register |
| dispDstArch | input | log2(ARCH_REGS) | Destination architectural index |
| dispSrc1Arch | input | log2(ARCH_REGS) | First source architectural index |
| dispSrc2Arch | input | log2(ARCH_REGS) | Second source architectural index |
| dispSrc1Tag | output | log2(PHYS_REGS) | Physical tag for first source |
| dispSrc2Tag | output | log2(PHYS_REGS) | Physical tag for second source |
| dispDstTag | output | log2(PHYS_REGS) | Newly granted destination tag, 0 when none granted |
| retValid | input | 1 | A destination-writing instruction commits |
| retDstArch | input | log2(ARCH_REGS) | Committing destination architectural index |
| retTag | input | log2(PHYS_REGS) | Physical tag of the committing instruction |
| flush | input | 1 | Restore speculative state from the retirement map |

## Verification
The bench builds the unit with ARCH_REGS=8, PHYS_REGS=12 and ZERO_REG=1. This leaves only four spare tags at reset, so the free vector runs dry after four allocations, and stalls, reuse of retired tags and lowest-first granting all come up within a few cycles. The small register count also lets a looping pattern cycle through every destination, and combine retires with flushes that land on a half-full and on an empty free vector.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

  // Strobes issued by the control half to the state-holding datapath.
  typedef struct packed {
    logic allocEn;    // grant a tag and remap the dispatch destination
    logic retEn;      // update the retirement map and release the displaced tag
    logic restoreEn;  // copy retirement map into speculative map, rebuild free vector
  } rnmStrobes_t;

endpackage

// File: rtl/rnm_ctrl.sv
module rnm_ctrl
  import rnm_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter bit ZERO_REG  = 1'b1,
  localparam int ATW = $clog2(ARCH_REGS)
) (
  input  logic            dispValid,
  input  logic            dispDstEn,
  input  logic [ATW-1:0]  dispDstArch,
  input  logic            retValid,
  input  logic [ATW-1:0]  retDstArch,
  input  logic            flush,
  input  logic            freeAvail,
  output logic            dispReady,
  output rnmStrobes_t     strobes
);

  logic dstIsZero;
  logic retIsZero;
  logic needAlloc;

  always_comb begin
    dstIsZero = ZERO_REG && (dispDstArch == '0);
    retIsZero = ZERO_REG && (retDstArch == '0);
    needAlloc = dispDstEn && !dstIsZero;

    // A flush cycle never accepts new work; an empty free vector stalls all.
    dispReady = freeAvail && !flush;

    strobes.allocEn   = dispValid && dispReady && needAlloc;
    strobes.retEn     = retValid && !retIsZero;
    strobes.restoreEn = flush;
  end

endmodule

// File: rtl/rnm_datapath.sv
module rnm_datapath
  import rnm_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int ATW = $clog2(ARCH_REGS),
  localparam int PTW = $clog2(PHYS_REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  rnmStrobes_t     strobes,
  input  logic [ATW-1:0]  dispDstArch,
  input  logic [ATW-1:0]  dispSrc1Arch,
  input  logic [ATW-1:0]  dispSrc2Arch,
  input  logic [ATW-1:0]  retDstArch,
  input  logic [PTW-1:0]  retTag,
  output logic [PTW-1:0]  dispSrc1Tag,
  output logic [PTW-1:0]  dispSrc2Tag,
  output logic [PTW-1:0]  dispDstTag,
  output logic            freeAvail
);

  logic [PTW-1:0]       specMap  [ARCH_REGS];
  logic [PTW-1:0]       rratMap  [ARCH_REGS];
  logic [PTW-1:0]       rratNext [ARCH_REGS];
  logic [PHYS_REGS-1:0] freeVec;
  logic [PHYS_REGS-1:0] freeNext;
  logic [PHYS_REGS-1:0] usedVec;
  logic [PTW-1:0]       grantTag;
  logic [PTW-1:0]       displacedTag;

  // Source lookup reads the map before this cycle's remap.
  assign dispSrc1Tag = specMap[dispSrc1Arch];
  assign dispSrc2Tag = specMap[dispSrc2Arch];
  assign dispDstTag  = strobes.allocEn ? grantTag : '0;

  // Lowest-numbered free register wins.
  always_comb begin
    grantTag  = '0;
    freeAvail = |freeVec;
    for (int p = PHYS_REGS - 1; p >= 0; p--) begin
      if (freeVec[p]) grantTag = PTW'(p);
    end
  end

  // Retirement map as it will be after this cycle's commit.
  assign displacedTag = rratMap[retDstArch];

  always_comb begin
    for (int a = 0; a < ARCH_REGS; a++) rratNext[a] = rratMap[a];
    if (strobes.retEn) rratNext[retDstArch] = retTag;
  end

  // Per physical register: is it referenced by the post-commit retirement map?
  for (genvar p = 0; p < PHYS_REGS; p++) begin : g_used
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int a = 0; a < ARCH_REGS; a++) begin
        if (rratNext[a] == PTW'(p)) hit = 1'b1;
      end
    end
    assign usedVec[p] = hit;
  end

  // Incremental free-vector update for ordinary cycles.
  always_comb begin
    freeNext = freeVec;
    if (strobes.allocEn) freeNext[grantTag]     = 1'b0;
    if (strobes.retEn)   freeNext[displacedTag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        specMap[a] <= PTW'(a);
        rratMap[a] <= PTW'(a);
      end
      for (int p = 0; p < PHYS_REGS; p++) begin
        freeVec[p] <= (p >= ARCH_REGS);
      end
    end else begin
      for (int a = 0; a < ARCH_REGS; a++) rratMap[a] <= rratNext[a];
      if (strobes.restoreEn) begin
        for (int a = 0; a < ARCH_REGS; a++) specMap[a] <= rratNext[a];
        freeVec <= ~usedVec;
      end else begin
        if (strobes.allocEn) specMap[dispDstArch] <= grantTag;
        freeVec <= freeNext;
      end
    end
  end

endmodule

// File: rtl/rnm_unit.sv
module rnm_unit
  import rnm_pkg::*;
#(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  parameter bit ZERO_REG  = 1'b1,
  localparam int ATW = $clog2(ARCH_REGS),
  localparam int PTW = $clog2(PHYS_REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dispValid,
  output logic            dispReady,
  input  logic            dispDstEn,
  input  logic [ATW-1:0]  dispDstArch,
  input  logic [ATW-1:0]  dispSrc1Arch,
  input  logic [ATW-1:0]  dispSrc2Arch,
  output logic [PTW-1:0]  dispSrc1Tag,
  output logic [PTW-1:0]  dispSrc2Tag,
  output logic [PTW-1:0]  dispDstTag,
  input  logic            retValid,
  input  logic [ATW-1:0]  retDstArch,
  input  logic [PTW-1:0]  retTag,
  input  logic            flush
);

  rnmStrobes_t strobes;
  logic        freeAvail;

  rnm_ctrl #(
    .ARCH_REGS (ARCH_REGS),
    .ZERO_REG  (ZERO_REG)
  ) u_ctrl (
    .dispValid   (dispValid),
    .dispDstEn   (dispDstEn),
    .dispDstArch (dispDstArch),
    .retValid    (retValid),
    .retDstArch  (retDstArch),
    .flush       (flush),
    .freeAvail   (freeAvail),
    .dispReady   (dispReady),
    .strobes     (strobes)
  );

  rnm_datapath #(
    .ARCH_REGS (ARCH_REGS),
    .PHYS_REGS (PHYS_REGS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .dispDstArch  (dispDstArch),
    .dispSrc1Arch (dispSrc1Arch),
    .dispSrc2Arch (dispSrc2Arch),
    .retDstArch   (retDstArch),
    .retTag       (retTag),
    .dispSrc1Tag  (dispSrc1Tag),
    .dispSrc2Tag  (dispSrc2Tag),
    .dispDstTag   (dispDstTag),
    .freeAvail    (freeAvail)
  );

endmodule

// File: rtl/rnm_unit_chk.sv
module rnm_unit_chk #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  parameter bit ZERO_REG  = 1'b1,
  localparam int ATW = $clog2(ARCH_REGS),
  localparam int PTW = $clog2(PHYS_REGS)
) (
  input logic            clk,
  input logic            rstN,
  input logic            dispValid,
  input logic            dispReady,
  input logic            dispDstEn,
  input logic [ATW-1:0]  dispDstArch,
  input logic [ATW-1:0]  dispSrc1Arch,
  input logic [ATW-1:0]  dispSrc2Arch,
  input logic [PTW-1:0]  dispSrc1Tag,
  input logic [PTW-1:0]  dispSrc2Tag,
  input logic [PTW-1:0]  dispDstTag,
  input logic            retValid,
  input logic [ATW-1:0]  retDstArch,
  input logic [PTW-1:0]  retTag,
  input logic            flush
);

  logic fireAlloc;
  logic [PTW-1:0] shadowRrat [ARCH_REGS];

  assign fireAlloc = dispValid && dispReady && dispDstEn &&
                     !(ZERO_REG && dispDstArch == '0);

  // Committed mapping rebuilt from the retire port alone.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < ARCH_REGS; a++) shadowRrat[a] <= PTW'(a);
    end else if (retValid && !(ZERO_REG && retDstArch == '0)) begin
      shadowRrat[retDstArch] <= retTag;
    end
  end

  AST_ZERO_SRC_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (ZERO_REG && dispSrc2Arch == '0) |-> dispSrc2Tag == '0); // R7

  AST_GRANT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    fireAlloc |-> dispDstTag != '0); // R7

  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(dispValid && dispReady) |-> dispDstTag == '0); // R8

  AST_REMAP_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    fireAlloc |=> (dispSrc1Arch != $past(dispDstArch)) ||
                  (dispSrc1Tag == $past(dispDstTag))); // R3

  AST_GRANTS_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    fireAlloc |=> (!fireAlloc || dispDstTag != $past(dispDstTag))); // R3

  AST_RESTORE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |-> dispSrc1Tag == shadowRrat[dispSrc1Arch]); // R6

endmodule

bind rnm_unit rnm_unit_chk #(
  .ARCH_REGS (ARCH_REGS),
  .PHYS_REGS (PHYS_REGS),
  .ZERO_REG  (ZERO_REG)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .dispValid    (dispValid),
  .dispReady    (dispReady),
  .dispDstEn    (dispDstEn),
  .dispDstArch  (dispDstArch),
  .dispSrc1Arch (dispSrc1Arch),
  .dispSrc2Arch (dispSrc2Arch),
  .dispSrc1Tag  (dispSrc1Tag),
  .dispSrc2Tag  (dispSrc2Tag),
  .dispDstTag   (dispDstTag),
  .retValid     (retValid),
  .retDstArch   (retDstArch),
  .retTag       (retTag),
  .flush        (flush)
);

// File: tb/rnm_unit_tb.sv
module rnm_unit_tb;

  localparam int AR  = 8;
  localparam int PR  = 12;
  localparam int ATW = $clog2(AR);
  localparam int PTW = $clog2(PR);

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           dispValid = 1'b0, dispDstEn = 1'b0;
  logic [ATW-1:0] dispDstArch = '0, dispSrc1Arch = '0, dispSrc2Arch = '0;
  logic           dispReady;
  logic [PTW-1:0] dispSrc1Tag, dispSrc2Tag, dispDstTag;
  logic           retValid = 1'b0;
  logic [ATW-1:0] retDstArch = '0;
  logic [PTW-1:0] retTag = '0;
  logic           flush = 1'b0;

  always #5 clk = ~clk;

  rnm_unit #(.ARCH_REGS(AR), .PHYS_REGS(PR), .ZERO_REG(1'b1)) u_dut (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispReady(dispReady), .dispDstEn(dispDstEn),
    .dispDstArch(dispDstArch), .dispSrc1Arch(dispSrc1Arch), .dispSrc2Arch(dispSrc2Arch),
    .dispSrc1Tag(dispSrc1Tag), .dispSrc2Tag(dispSrc2Tag), .dispDstTag(dispDstTag),
    .retValid(retValid), .retDstArch(retDstArch), .retTag(retTag), .flush(flush)
  );

  // Reference model built from the requirements.
  int  mSpec [AR];
  int  mRrat [AR];
  bit  mFree [PR];

  // Scoreboard queues, one entry per applied vector.
  int    qReady[$], qS1[$], qS2[$], qDst[$];
  string qReq[$];

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Bench-side in-flight instruction record for program-order retire.
  int robArch[$], robTag[$];

  task automatic check(input int act, input int exp, input string req, input string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int a = 0; a < AR; a++) begin mSpec[a] = a; mRrat[a] = a; end
    for (int p = 0; p < PR; p++) mFree[p] = (p >= AR);
  endtask

  // Drive one cycle, push the expected outputs, advance the model.
  task automatic step(input bit dv, input bit dEn, input int dDst, input int s1, input int s2,
                      input bit rv, input int rDst, input int rTag, input bit fl,
                      input string req, output bit fired, output int gTag);
    bit anyFree;
    int low;
    bit ready, alloc;
    @(negedge clk);
    dispValid = dv; dispDstEn = dEn; dispDstArch = ATW'(dDst);
    dispSrc1Arch = ATW'(s1); dispSrc2Arch = ATW'(s2);
    retValid = rv; retDstArch = ATW'(rDst); retTag = PTW'(rTag); flush = fl;

    anyFree = 1'b0; low = 0;
    for (int p = PR - 1; p >= 0; p--) if (mFree[p]) begin anyFree = 1'b1; low = p; end
    ready = anyFree && !fl;
    fired = dv && ready;
    alloc = fired && dEn && (dDst != 0);
    gTag  = alloc ? low : 0;

    qReady.push_back(int'(ready)); qS1.push_back(mSpec[s1]); qS2.push_back(mSpec[s2]);
    qDst.push_back(gTag); qReq.push_back(req);

    if (rv && rDst != 0) begin
      if (!fl) mFree[mRrat[rDst]] = 1'b1;
      mRrat[rDst] = rTag;
    end
    if (fl) begin
      for (int p = 0; p < PR; p++) mFree[p] = 1'b1;
      for (int a = 0; a < AR; a++) begin mSpec[a] = mRrat[a]; mFree[mRrat[a]] = 1'b0; end
    end else if (alloc) begin
      mSpec[dDst] = low;
      mFree[low]  = 1'b0;
    end
  endtask

  // Monitor: compare outputs mid-cycle, after the inputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (qReq.size() > 0) begin
        string r;
        r = qReq.pop_front();
        check(int'(dispReady),   qReady.pop_front(), r, "dispReady");
        check(int'(dispSrc1Tag), qS1.pop_front(),    r, "dispSrc1Tag");
        check(int'(dispSrc2Tag), qS2.pop_front(),    r, "dispSrc2Tag");
        check(int'(dispDstTag),  qDst.pop_front(),   r, "dispDstTag");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit f;
    int t, tagA, tagB, tagE;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: identity mapping after reset, source index i reads tag i
    step(0,0,0, 3,5, 0,0,0, 0, "R1", f, t);
    step(0,0,0, 6,7, 0,0,0, 0, "R1", f, t);
    // R7: zero register reads tag 0
    step(0,0,0, 0,0, 0,0,0, 0, "R7", f, t);
    // R3/R1: first grant is lowest spare tag (8)
    step(1,1,1, 2,3, 0,0,0, 0, "R3", f, tagA);
    // R2: new tag for R1, old tag for R3 (own destination)
    step(1,1,3, 1,3, 0,0,0, 0, "R2", f, tagB);
    // R7: destination 0 allocates nothing
    step(1,1,0, 3,0, 0,0,0, 0, "R7", f, t);
    // R8: no destination enable, no grant
    step(1,0,5, 3,1, 0,0,0, 0, "R8", f, t);
    step(1,1,4, 4,3, 0,0,0, 0, "R3", f, tagE);
    step(1,1,5, 5,4, 0,0,0, 0, "R3", f, t);
    // R4: free vector empty, dispatch stalls and changes nothing
    step(1,1,6, 6,5, 0,0,0, 0, "R4", f, t);
    step(0,0,0, 6,5, 0,0,0, 0, "R4", f, t);
    // R5: retire A frees displaced tag 1, which is granted next cycle
    step(1,1,6, 1,6, 1,1,tagA, 0, "R5", f, t);
    step(1,1,6, 6,1, 0,0,0, 0, "R5", f, t);
    // R7: retire to register 0 ignored; R5 retire B
    step(0,0,0, 0,3, 1,0,5, 0, "R7", f, t);
    step(0,0,0, 3,0, 1,3,tagB, 0, "R5", f, t);
    // R6: flush with same-cycle retire of E; dispatch ignored
    step(1,1,2, 1,4, 1,4,tagE, 1, "R6", f, t);
    step(0,0,0, 4,6, 0,0,0, 0, "R6", f, t);
    step(0,0,0, 5,2, 0,0,0, 0, "R6", f, t);
    step(1,1,7, 7,3, 0,0,0, 0, "R6", f, t);

    // Mixed pattern: in-order retire, periodic flush, all destinations.
    robArch.delete(); robTag.delete();
    robArch.push_back(7); robTag.push_back(t);
    for (int i = 0; i < 60; i++) begin
      bit rv, fl;
      int rA, rT, d;
      fl = (i % 13 == 12);
      rv = 1'b0; rA = 0; rT = 0;
      if (robArch.size() >= 3 || (fl && robArch.size() > 0) || (i % 4 == 1 && robArch.size() > 0)) begin
        rv = 1'b1; rA = robArch.pop_front(); rT = robTag.pop_front();
      end
      d = (i * 3) % AR;
      step(1, (i % 7 != 3), d, i % AR, (i * 5) % AR, rv, rA, rT, fl,
           fl ? "R6" : (rv ? "R5" : "R3"), f, t);
      if (fl) begin
        robArch.delete(); robTag.delete();
      end else if (t != 0) begin
        robArch.push_back(d); robTag.push_back(t);
      end
    end

    step(0,0,0, 1,2, 0,0,0, 0, "R2", f, t);
    @(negedge clk);
    #4;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule